// File: doc/BRIEF.md
# Multi-Channel Module Lock Arbiter

This block holds a small table of hardware mutexes, one for each shared processing unit. Several command channels share it. Each channel shows the command word it is about to execute, together with a valid flag. The block decides at once whether that word may retire. If it can, the block pulses that channel's ack in the same cycle. If it cannot, it holds the ack low and the channel keeps presenting the word. Lock operations are ordinary words in the command stream: an acquire takes a unit for the issuing channel, and a matching release frees it again. Words that are not lock operations retire at once.

Lock 0 belongs to the host's own class and is never actually taken. A word-addressed register port lets software read each lock's state and the sticky error flag. The same port lets software force-free a lock whose holder has hung, once a timeout has passed.

Top module: `mlock_arbiter`

## Requirements
- R1: A word is a lock operation only when bits [31:28] equal 14 (0xE). Any other word is acked in the cycle it is presented and changes no lock state.
- R2: An acquire (0xE, bit 24 = 0, lock ID in bits [7:0]) on a free lock is acked in the cycle it is presented. From the next cycle on, the lock reads as held by that channel.
- R3: An acquire on a lock held by another channel gets no ack, and the channel keeps presenting the word. It is acked in the first cycle the lock is free. An acquire by the current owner is acked at once and leaves the state unchanged.
- R4: When several channels present an acquire for the same free lock in one cycle, only the lowest-numbered one is acked and becomes owner. The others stall.
- R5: A release (0xE, bit 24 = 1) from the owner is acked at once. The lock is then free with owner 0.
- R6: A release from a channel that is not the owner, or a release on a lock that is not held, is acked and leaves the lock state unchanged.
- R7: An acquire or release on lock 0 is acked at once, and lock 0 always reads as free.
- R8: The status of lock i is read at byte address 4*i: bit 0 is the locked flag, bits [7:2] are the owning channel, and all other bits are zero. An address with nonzero bits [1:0] reads zero and ignores writes.
- R9: Writing zero to lock i's address frees the lock and clears its owner, and a stalled acquirer then gets the lock one cycle later. Writing a nonzero value there has no effect.
- R10: A lock operation whose ID is not below NUM_LOCKS is acked, changes no lock, and sets a sticky error bit. The error bit is bit 0 at byte address 4*NUM_LOCKS. Writing a value with bit 0 set clears it; any other write there leaves it set.
- R11: After reset every lock is free with owner 0, and the error bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_valid | input | NUM_CH | Channel c is presenting a word |
| ch_word | input | NUM_CH*32 | Command words, channel c in bits [32c+31:32c] |
| ch_ack | output | NUM_CH | Word of channel c retires this cycle |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |

## Verification
The assertions assume that a channel keeps its valid flag and word steady until it sees its ack, and that NUM_CH fits the 6-bit owner field. The stall and owner-stability properties rely on that hold-until-ack behaviour. The bench drives every channel through one task. That task raises valid just after a clock edge, holds it until the ack appears, and drops it only after the next edge. Register writes last exactly one cycle. Parallel requests are launched in the same cycle only to exercise the priority rule.

// File: rtl/mlock_pkg.sv
`timescale 1ns/1ps
package mlock_pkg;
  localparam int WORD_W = 32;
  localparam int OWN_W  = 6;
  localparam int ID_W   = 8;
  localparam logic [3:0] LOCK_OPC = 4'hE;

  typedef struct packed {
    logic            is_lock;
    logic            is_rel;
    logic [ID_W-1:0] id;
  } lock_cmd_t;

  function automatic lock_cmd_t decode_word(input logic [WORD_W-1:0] w);
    lock_cmd_t r;
    r.is_lock = (w[31:28] == LOCK_OPC);
    r.is_rel  = w[24];
    r.id      = w[ID_W-1:0];
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic held,
                                                    input logic [OWN_W-1:0] own);
    return {{(WORD_W-OWN_W-2){1'b0}}, own, 1'b0, held};
  endfunction
endpackage

// File: rtl/mlock_decode.sv
`timescale 1ns/1ps
module mlock_decode
  import mlock_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LOCKS = 8
) (
  input  logic [NUM_CH-1:0]           ch_valid,
  input  logic [NUM_CH*WORD_W-1:0]    ch_word,
  output logic [NUM_CH-1:0]           imm_ack,
  output logic [NUM_CH-1:0]           acq_req,
  output logic [NUM_CH-1:0]           rel_req,
  output logic [NUM_CH-1:0]           bad_id,
  output logic [NUM_CH-1:0][ID_W-1:0] cmd_id
);
  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      lock_cmd_t cmd;
      logic      host;
      logic      in_range;
      assign cmd      = decode_word(ch_word[c*WORD_W +: WORD_W]);
      assign host     = (cmd.id == '0);
      assign in_range = (32'(cmd.id) < 32'(NUM_LOCKS));
      assign imm_ack[c] = ch_valid[c] &
                          (!cmd.is_lock | cmd.is_rel | host | !in_range);
      assign acq_req[c] = ch_valid[c] & cmd.is_lock & !cmd.is_rel & !host & in_range;
      assign rel_req[c] = ch_valid[c] & cmd.is_lock & cmd.is_rel & !host & in_range;
      assign bad_id[c]  = ch_valid[c] & cmd.is_lock & !in_range;
      assign cmd_id[c]  = cmd.id;
    end
  endgenerate
endmodule

// File: rtl/mlock_arb.sv
`timescale 1ns/1ps
module mlock_arb
  import mlock_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LOCKS = 8
) (
  input  logic [NUM_CH-1:0]              acq_req,
  input  logic [NUM_CH-1:0]              rel_req,
  input  logic [NUM_CH-1:0][ID_W-1:0]    cmd_id,
  input  logic [NUM_LOCKS-1:0]           locked,
  input  logic [NUM_LOCKS-1:0][OWN_W-1:0] owner,
  output logic [NUM_LOCKS-1:0][NUM_CH-1:0] grant,
  output logic [NUM_LOCKS-1:0][NUM_CH-1:0] reacq,
  output logic [NUM_LOCKS-1:0]           rel_fire,
  output logic [NUM_CH-1:0]              acq_ack
);
  // isolate the lowest set bit: lowest channel number wins
  function automatic logic [NUM_CH-1:0] lowest_one(input logic [NUM_CH-1:0] v);
    return v & (~v + NUM_CH'(1));
  endfunction

  generate
    for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lock
      if (l == 0) begin : g_host
        assign grant[l]    = '0;
        assign reacq[l]    = '0;
        assign rel_fire[l] = 1'b0;
      end else begin : g_unit
        logic [NUM_CH-1:0] want;
        logic [NUM_CH-1:0] owner_is;
        logic [NUM_CH-1:0] rel_hit;
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
          assign want[c]     = acq_req[c] && (cmd_id[c] == ID_W'(l));
          assign owner_is[c] = (owner[l] == OWN_W'(c));
          assign rel_hit[c]  = rel_req[c] && (cmd_id[c] == ID_W'(l)) && owner_is[c];
        end
        assign grant[l]    = locked[l] ? '0 : lowest_one(want);
        assign reacq[l]    = locked[l] ? (want & owner_is) : '0;
        assign rel_fire[l] = locked[l] && (|rel_hit);
      end
    end
  endgenerate

  always_comb begin
    acq_ack = '0;
    for (int l = 0; l < NUM_LOCKS; l++) acq_ack = acq_ack | grant[l] | reacq[l];
  end
endmodule

// File: rtl/mlock_table.sv
`timescale 1ns/1ps
module mlock_table
  import mlock_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LOCKS = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LOCKS-1:0][NUM_CH-1:0] grant,
  input  logic [NUM_LOCKS-1:0]            rel_fire,
  input  logic                            bad_any,
  input  logic [ADDR_W-1:0]               reg_addr,
  input  logic                            reg_wr,
  input  logic [WORD_W-1:0]               reg_wdata,
  output logic [NUM_LOCKS-1:0]            locked,
  output logic [NUM_LOCKS-1:0][OWN_W-1:0] owner,
  output logic                            err,
  output logic                            err_clr,
  output logic [NUM_LOCKS-1:0]            sw_clr,
  output logic [WORD_W-1:0]               reg_rdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  assign idx     = reg_addr[ADDR_W-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  function automatic logic [OWN_W-1:0] idx_of(input logic [NUM_CH-1:0] v);
    logic [OWN_W-1:0] r;
    r = '0;
    for (int c = 0; c < NUM_CH; c++) if (v[c]) r = OWN_W'(c);
    return r;
  endfunction

  generate
    for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_slot
      assign sw_clr[l] = reg_wr && aligned && (idx == IDX_W'(l)) && (reg_wdata == '0);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          locked[l] <= 1'b0;
          owner[l]  <= '0;
        end else if (|grant[l]) begin
          locked[l] <= 1'b1;
          owner[l]  <= idx_of(grant[l]);
        end else if (rel_fire[l] || sw_clr[l]) begin
          locked[l] <= 1'b0;
          owner[l]  <= '0;
        end
      end
    end
  endgenerate

  assign err_clr = reg_wr && aligned && (idx == IDX_W'(NUM_LOCKS)) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (bad_any) err <= 1'b1;
    else if (err_clr) err <= 1'b0;
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      for (int l = 0; l < NUM_LOCKS; l++)
        if (idx == IDX_W'(l)) reg_rdata = status_word(locked[l], owner[l]);
      if (idx == IDX_W'(NUM_LOCKS)) reg_rdata = {{(WORD_W-1){1'b0}}, err};
    end
  end
endmodule

// File: rtl/mlock_arbiter.sv
`timescale 1ns/1ps
module mlock_arbiter
  import mlock_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LOCKS = 8,
  parameter int ADDR_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CH-1:0]         ch_valid,
  input  logic [NUM_CH*WORD_W-1:0]  ch_word,
  output logic [NUM_CH-1:0]         ch_ack,
  input  logic [ADDR_W-1:0]         reg_addr,
  input  logic                      reg_wr,
  input  logic [WORD_W-1:0]         reg_wdata,
  output logic [WORD_W-1:0]         reg_rdata
);
  logic [NUM_CH-1:0]               imm_ack_w;
  logic [NUM_CH-1:0]               acq_req_w;
  logic [NUM_CH-1:0]               rel_req_w;
  logic [NUM_CH-1:0]               bad_id_w;
  logic [NUM_CH-1:0][ID_W-1:0]     cmd_id_w;
  logic [NUM_LOCKS-1:0][NUM_CH-1:0] grant_w;
  logic [NUM_LOCKS-1:0][NUM_CH-1:0] reacq_w;
  logic [NUM_LOCKS-1:0]            rel_fire_w;
  logic [NUM_CH-1:0]               acq_ack_w;
  logic [NUM_LOCKS-1:0]            locked_w;
  logic [NUM_LOCKS-1:0][OWN_W-1:0] owner_w;
  logic                            err_w;
  logic                            err_clr_w;
  logic [NUM_LOCKS-1:0]            sw_clr_w;

  mlock_decode #(.NUM_CH(NUM_CH), .NUM_LOCKS(NUM_LOCKS)) u_decode (
    .ch_valid (ch_valid),
    .ch_word  (ch_word),
    .imm_ack  (imm_ack_w),
    .acq_req  (acq_req_w),
    .rel_req  (rel_req_w),
    .bad_id   (bad_id_w),
    .cmd_id   (cmd_id_w)
  );

  mlock_arb #(.NUM_CH(NUM_CH), .NUM_LOCKS(NUM_LOCKS)) u_arb (
    .acq_req  (acq_req_w),
    .rel_req  (rel_req_w),
    .cmd_id   (cmd_id_w),
    .locked   (locked_w),
    .owner    (owner_w),
    .grant    (grant_w),
    .reacq    (reacq_w),
    .rel_fire (rel_fire_w),
    .acq_ack  (acq_ack_w)
  );

  mlock_table #(.NUM_CH(NUM_CH), .NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant_w),
    .rel_fire  (rel_fire_w),
    .bad_any   (|bad_id_w),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .locked    (locked_w),
    .owner     (owner_w),
    .err       (err_w),
    .err_clr   (err_clr_w),
    .sw_clr    (sw_clr_w),
    .reg_rdata (reg_rdata)
  );

  assign ch_ack = imm_ack_w | acq_ack_w;
endmodule

// File: rtl/mlock_arbiter_chk.sv
`timescale 1ns/1ps
module mlock_arbiter_chk
  import mlock_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int NUM_LOCKS = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [NUM_CH-1:0]               ch_valid,
  input logic [NUM_CH*WORD_W-1:0]        ch_word,
  input logic [NUM_CH-1:0]               ch_ack,
  input logic [NUM_LOCKS-1:0][NUM_CH-1:0] grant,
  input logic [NUM_LOCKS-1:0]            locked,
  input logic [NUM_LOCKS-1:0][OWN_W-1:0] owner,
  input logic                            err,
  input logic                            err_clr
);
  logic [NUM_CH-1:0] foreign_stall;

  always_comb begin
    foreign_stall = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_valid[c] && ch_word[c*WORD_W+28 +: 4] == 4'hE && !ch_word[c*WORD_W+24]) begin
        for (int l = 1; l < NUM_LOCKS; l++)
          if (ch_word[c*WORD_W +: ID_W] == ID_W'(l) && locked[l] && owner[l] != OWN_W'(c))
            foreign_stall[c] = 1'b1;
      end
    end
  end

  a_r1_ack_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid == ch_valid |-> (ch_ack & ~ch_valid) == '0);

  a_r3_foreign_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (foreign_stall != '0) |-> (ch_ack & foreign_stall) == '0);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err) && !$past(err_clr)) |-> err);

  a_r7_host_free: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid == ch_valid |-> !locked[0]);

  generate
    for (genvar l = 0; l < NUM_LOCKS; l++) begin : g_lk
      a_r4_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant[l]) |-> $onehot0(grant[l]));
      a_r2_rise_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked[l]) |-> $past(|ch_ack));
      a_r3_owner_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (locked[l] && $past(locked[l])) |-> $stable(owner[l]));
      a_r5_free_owner_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !locked[l] |-> owner[l] == '0);
    end
  endgenerate
endmodule

bind mlock_arbiter mlock_arbiter_chk #(.NUM_CH(NUM_CH), .NUM_LOCKS(NUM_LOCKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ch_valid (ch_valid),
  .ch_word  (ch_word),
  .ch_ack   (ch_ack),
  .grant    (grant_w),
  .locked   (locked_w),
  .owner    (owner_w),
  .err      (err_w),
  .err_clr  (err_clr_w)
);

// File: tb/mlock_arbiter_bench.sv
`timescale 1ns/1ps
module mlock_arbiter_bench;
  localparam int NCH = 4;
  localparam int NLK = 8;
  localparam int AW  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    ch_valid = '0;
  logic [NCH*32-1:0] ch_word = '0;
  logic [NCH-1:0]    ch_ack;
  logic [AW-1:0]     reg_addr = '0;
  logic              reg_wr = 1'b0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  bit    busy [NCH];
  int    exp_ch [$];
  string exp_tag [$];

  always #2.5 clk = ~clk;

  mlock_arbiter #(.NUM_CH(NCH), .NUM_LOCKS(NLK), .ADDR_W(AW)) u_mlock_arbiter (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_word(ch_word), .ch_ack(ch_ack),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // expected status word: locked in bit 0, owner in bits [7:2]
  function automatic logic [31:0] st(input bit held, input int own);
    return held ? (32'h1 | (32'(own) << 2)) : 32'h0;
  endfunction

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard: expected retirements, popped by the monitor
  task automatic expect_ack(input int c, input string tag);
    exp_ch.push_back(c);
    exp_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        if (ch_ack[c]) begin
          if (exp_ch.size() == 0) begin
            chk(0, "unexpected ack", c, -1);
          end else begin
            int    e;
            string t;
            e = exp_ch.pop_front();
            t = exp_tag.pop_front();
            chk(e == c, t, c, e);
          end
        end
      end
    end
  end

  task automatic issue(input int c, input logic [31:0] w);
    @(posedge clk); #1;
    ch_word[c*32 +: 32] = w;
    ch_valid[c] = 1'b1;
    busy[c] = 1;
    do @(negedge clk); while (!ch_ack[c]);
    @(posedge clk); #1;
    ch_valid[c] = 1'b0;
    busy[c] = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata === exp, tag, int'(reg_rdata), int'(exp));
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    for (int c = 0; c < NCH; c++) busy[c] = 0;
    cyc(3); #1 rst_n = 1'b1;

    // R11: reset state
    rd(8'h04, st(0, 0), "R11 lock1");
    rd(8'h1C, st(0, 0), "R11 lock7");
    rd(8'h20, 32'h0, "R11 err");

    // R1: non-lock words retire at once
    expect_ack(0, "R1");
    issue(0, 32'h1000_0005);
    expect_ack(0, "R1");
    issue(0, 32'hD000_0005);
    rd(8'h14, st(0, 0), "R1 no effect");

    // R2: acquire free lock
    expect_ack(1, "R2");
    issue(1, 32'hE000_0003);
    rd(8'h0C, st(1, 1), "R2 held by ch1");

    // R3: foreign acquire stalls, owner re-acquire passes
    fork issue(2, 32'hE000_0003); join_none
    cyc(4);
    chk(busy[2], "R3 stall", 0, 1);
    expect_ack(1, "R3 reacquire");
    issue(1, 32'hE000_0003);
    rd(8'h0C, st(1, 1), "R3 unchanged");

    // R6: non-owner release and release of free lock
    expect_ack(0, "R6");
    issue(0, 32'hE100_0003);
    rd(8'h0C, st(1, 1), "R6 foreign release");
    chk(busy[2], "R6 still stalled", 0, 1);
    expect_ack(0, "R6");
    issue(0, 32'hE100_0006);
    rd(8'h18, st(0, 0), "R6 free release");

    // R5 / R3: owner release hands lock to the stalled channel
    expect_ack(1, "R5");
    expect_ack(2, "R3 handover");
    issue(1, 32'hE100_0003);
    while (busy[2]) @(posedge clk);
    rd(8'h0C, st(1, 2), "R3 held by ch2");
    expect_ack(2, "R5");
    issue(2, 32'hE100_0003);
    rd(8'h0C, st(0, 0), "R5 freed");

    // R4: same-cycle contention, lowest channel wins
    expect_ack(1, "R4");
    fork
      issue(1, 32'hE000_0004);
      issue(3, 32'hE000_0004);
    join_none
    cyc(4);
    chk(busy[3], "R4 loser stalls", 0, 1);
    rd(8'h10, st(1, 1), "R4 winner");

    // R9: software force-free
    wr(8'h10, 32'h1);
    rd(8'h10, st(1, 1), "R9 nonzero ignored");
    chk(busy[3], "R9 still stalled", 0, 1);
    expect_ack(3, "R9 after clear");
    wr(8'h10, 32'h0);
    while (busy[3]) @(posedge clk);
    rd(8'h10, st(1, 3), "R9 regranted");
    wr(8'h08, 32'h5);
    rd(8'h08, st(0, 0), "R9 free lock nonzero");

    // R8: misaligned accesses
    wr(8'h11, 32'h0);
    rd(8'h10, st(1, 3), "R8 misaligned write");
    rd(8'h11, 32'h0, "R8 misaligned read");

    // R7: host-class lock
    expect_ack(0, "R7");
    issue(0, 32'hE000_0000);
    expect_ack(1, "R7");
    issue(1, 32'hE000_0000);
    rd(8'h00, st(0, 0), "R7 never held");
    expect_ack(0, "R7");
    issue(0, 32'hE100_0000);
    rd(8'h00, st(0, 0), "R7 release");

    // R10: out-of-range ID
    expect_ack(0, "R10");
    issue(0, 32'hE000_0009);
    rd(8'h20, 32'h1, "R10 err set");
    rd(8'h04, st(0, 0), "R10 no alias");
    wr(8'h20, 32'h0);
    rd(8'h20, 32'h1, "R10 sticky");
    wr(8'h20, 32'h1);
    rd(8'h20, 32'h0, "R10 cleared");

    cyc(2);
    chk(exp_ch.size() == 0, "scoreboard drained", exp_ch.size(), 0);
    report();
  end
endmodule